// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block turns one interrupt route (a destination ID, a destination mode, a delivery mode and a vector) into per-processor strobes. It first resolves the route against a table of up to `NUM_CPU` processors. Each processor has a present flag, a physical ID and a logical ID. The result is a target mask. The block then dispatches according to the delivery mode: a vector strobe to every target, a vector strobe to one chosen target, an NMI strobe to every target, or nothing at all. The choice of a single target for lowest-priority delivery comes from outside as a processor index. This block only applies that choice and falls back safely when the choice is not a valid target.

A request is presented for one cycle with `req_valid`. The resulting strobes, the vector and the injected flag appear as a one-cycle pulse on the next clock. The source pin number matters only for pin 0, which is always steered to processor 0.

Top module: `ird_dispatch`

## Requirements
- R1: In physical mode (`req_dest_mode` = 0), a destination of all ones (0xFF) targets every present processor.
- R2: In physical mode with any other destination, only the lowest-index present processor whose physical ID equals the destination is targeted. A destination that matches no processor targets nobody.
- R3: In logical mode (`req_dest_mode` = 1), a destination of zero targets no processor.
- R4: In logical mode with a nonzero destination, every present processor whose logical ID shares at least one set bit with the destination is targeted.
- R5: When the target set is empty, no strobe fires, `vec_out` is zero and `injected` is 0. `injected` is 1 exactly when some bit of `vec_strobe` is set.
- R6: Fixed delivery (`req_dlv_mode` = 3'b000) raises `vec_strobe` for every target in the same cycle, with `req_vector` on `vec_out`.
- R7: Lowest-priority delivery (`req_dlv_mode` = 3'b001) raises exactly one `vec_strobe` bit. That bit is `lp_choice` when that processor is a target; otherwise it is the lowest-index target.
- R8: For source pin 0 with a nonempty target set, fixed and lowest-priority delivery both strobe processor 0 only. If processor 0 is absent, nothing is delivered.
- R9: NMI delivery (`req_dlv_mode` = 3'b100) raises `nmi_strobe` for every target, leaves `vec_strobe` at zero and reports `injected` = 0.
- R10: Any other `req_dlv_mode` encoding delivers nothing.
- R11: Outputs are registered. A request sampled at one rising edge yields a one-cycle pulse after that edge. Outputs are all zero during reset and in any cycle that follows an edge without `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A route request is present this cycle |
| req_pin | input | PIN_W | Source pin number of the request |
| req_dest | input | ID_W | Destination ID |
| req_dest_mode | input | 1 | 0 physical, 1 logical |
| req_dlv_mode | input | 3 | Delivery mode encoding |
| req_vector | input | VEC_W | Interrupt vector |
| cpu_present | input | NUM_CPU | One bit per processor that exists |
| cpu_phys_id | input | NUM_CPU*ID_W | Packed physical IDs, processor i at bits i*ID_W upward |
| cpu_logic_id | input | NUM_CPU*ID_W | Packed logical IDs, same packing |
| lp_choice | input | log2(NUM_CPU) | Externally chosen processor for lowest-priority delivery |
| vec_strobe | output | NUM_CPU | Vector injection pulse per processor |
| vec_out | output | VEC_W | Vector accompanying `vec_strobe`, zero otherwise |
| nmi_strobe | output | NUM_CPU | NMI pulse per processor |
| injected | output | 1 | A vector was delivered to at least one processor |

## Verification
The embedded properties watch, on every cycle, the invariants that hold whatever the stimulus. A target set never includes an absent processor. A physical non-broadcast lookup never yields more than one target. Vector and NMI strobes never fire together. `injected` agrees with the vector strobes. Lowest-priority and pin-0 deliveries never strobe more than one processor. No pulse follows an idle cycle. Which processors receive the pulse is shown only by the bench's scenarios, checked against its independent model. Those cases are the duplicate-ID first match, the logical overlap rule, the fallback when `lp_choice` is not a target, pin 0 with processor 0 absent, and the dropped mode encodings.

// File: rtl/ird_pkg.sv
package ird_pkg;
   localparam logic [2:0] DLV_FIXED  = 3'b000;
   localparam logic [2:0] DLV_LOWPRI = 3'b001;
   localparam logic [2:0] DLV_NMI    = 3'b100;
   localparam logic       DM_PHYS    = 1'b0;
   localparam logic       DM_LOGIC   = 1'b1;
endpackage

// File: rtl/ird_target_match.sv
module ird_target_match
   import ird_pkg::*;
#(
   parameter int NUM_CPU = 8,
   parameter int ID_W    = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    check_en,
   input  logic [ID_W-1:0]         dest,
   input  logic                    dest_mode,
   input  logic [NUM_CPU-1:0]      present,
   input  logic [NUM_CPU*ID_W-1:0] phys_ids,
   input  logic [NUM_CPU*ID_W-1:0] logic_ids,
   output logic [NUM_CPU-1:0]      mask
);
   localparam logic [ID_W-1:0] BCAST = '1;

   logic [NUM_CPU-1:0] phys_hit;
   logic [NUM_CPU-1:0] log_hit;
   logic [NUM_CPU-1:0] phys_first;

   for (genvar gi = 0; gi < NUM_CPU; gi++) begin : g_cpu
      assign phys_hit[gi] = present[gi] && (phys_ids[gi*ID_W +: ID_W] == dest);
      assign log_hit[gi]  = present[gi] && ((logic_ids[gi*ID_W +: ID_W] & dest) != '0);
   end

   // keep only the lowest-index physical hit
   always_comb begin
      phys_first = '0;
      for (int i = NUM_CPU - 1; i >= 0; i--) begin
         if (phys_hit[i]) begin
            phys_first    = '0;
            phys_first[i] = 1'b1;
         end
      end
   end

   always_comb begin
      if (dest_mode == DM_PHYS)
         mask = (dest == BCAST) ? present : phys_first;
      else if (dest == '0)
         mask = '0;
      else
         mask = log_hit;
   end

   assert_phys_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (check_en && dest_mode == DM_PHYS && dest != BCAST) |-> $onehot0(mask));
   assert_only_present_R1: assert property (@(posedge clk) disable iff (!rst_n)
      check_en |-> ((mask & ~present) == '0));
   assert_logic_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (check_en && dest_mode == DM_LOGIC && dest == '0) |-> (mask == '0));
endmodule

// File: rtl/ird_pick_one.sv
module ird_pick_one #(
   parameter int NUM_CPU = 8,
   parameter int IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               check_en,
   input  logic [NUM_CPU-1:0] cand,
   input  logic [IDX_W-1:0]   choice,
   output logic [NUM_CPU-1:0] pick
);
   logic [NUM_CPU-1:0] lowest;
   logic [NUM_CPU-1:0] chosen;

   always_comb begin
      lowest = '0;
      chosen = '0;
      for (int i = NUM_CPU - 1; i >= 0; i--) begin
         if (cand[i]) begin
            lowest    = '0;
            lowest[i] = 1'b1;
         end
         if (cand[i] && (int'(choice) == i))
            chosen[i] = 1'b1;
      end
      pick = (chosen != '0) ? chosen : lowest;
   end

   assert_pick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (check_en && cand != '0) |-> ($onehot(pick) && ((pick & ~cand) == '0)));
endmodule

// File: rtl/ird_dispatch.sv
module ird_dispatch
   import ird_pkg::*;
#(
   parameter int NUM_CPU = 8,
   parameter int ID_W    = 8,
   parameter int VEC_W   = 8,
   parameter int PIN_W   = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [PIN_W-1:0]           req_pin,
   input  logic [ID_W-1:0]            req_dest,
   input  logic                       req_dest_mode,
   input  logic [2:0]                 req_dlv_mode,
   input  logic [VEC_W-1:0]           req_vector,
   input  logic [NUM_CPU-1:0]         cpu_present,
   input  logic [NUM_CPU*ID_W-1:0]    cpu_phys_id,
   input  logic [NUM_CPU*ID_W-1:0]    cpu_logic_id,
   input  logic [$clog2(NUM_CPU)-1:0] lp_choice,
   output logic [NUM_CPU-1:0]         vec_strobe,
   output logic [VEC_W-1:0]           vec_out,
   output logic [NUM_CPU-1:0]         nmi_strobe,
   output logic                       injected
);
   localparam int IDX_W = $clog2(NUM_CPU);

   if (NUM_CPU < 2 || NUM_CPU > 32) begin : g_bad_cpu
      $error("ird_dispatch: NUM_CPU must lie in 2..32");
   end
   if (ID_W < 1 || VEC_W < 1 || PIN_W < 1) begin : g_bad_width
      $error("ird_dispatch: widths must be positive");
   end

   logic [NUM_CPU-1:0] tgt_mask;
   logic [NUM_CPU-1:0] lp_pick;
   logic [NUM_CPU-1:0] cpu0_only;
   logic [NUM_CPU-1:0] vec_nxt;
   logic [NUM_CPU-1:0] nmi_nxt;
   logic               pin_zero;
   logic               inj_nxt;
   logic               any_tgt;

   ird_target_match #(.NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .check_en  (req_valid),
      .dest      (req_dest),
      .dest_mode (req_dest_mode),
      .present   (cpu_present),
      .phys_ids  (cpu_phys_id),
      .logic_ids (cpu_logic_id),
      .mask      (tgt_mask)
   );

   ird_pick_one #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .check_en (req_valid),
      .cand     (tgt_mask),
      .choice   (lp_choice),
      .pick     (lp_pick)
   );

   assign pin_zero = (req_pin == '0);
   assign any_tgt  = (tgt_mask != '0);

   always_comb begin
      cpu0_only    = '0;
      cpu0_only[0] = cpu_present[0];
   end

   always_comb begin
      vec_nxt = '0;
      nmi_nxt = '0;
      if (req_valid && any_tgt) begin
         case (req_dlv_mode)
            DLV_FIXED:  vec_nxt = pin_zero ? cpu0_only : tgt_mask;
            DLV_LOWPRI: vec_nxt = pin_zero ? cpu0_only : lp_pick;
            DLV_NMI:    nmi_nxt = tgt_mask;
            default:    ;
         endcase
      end
   end

   // delivery flag derived from the route conditions, not from vec_nxt
   assign inj_nxt = req_valid && any_tgt
                    && (req_dlv_mode == DLV_FIXED || req_dlv_mode == DLV_LOWPRI)
                    && (!pin_zero || cpu_present[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_strobe <= '0;
         nmi_strobe <= '0;
         vec_out    <= '0;
         injected   <= 1'b0;
      end else begin
         vec_strobe <= vec_nxt;
         nmi_strobe <= nmi_nxt;
         vec_out    <= inj_nxt ? req_vector : '0;
         injected   <= inj_nxt;
      end
   end

   assert_no_mix_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_strobe != '0) |-> (nmi_strobe == '0));
   assert_flag_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      injected == (vec_strobe != '0));
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (vec_strobe == '0 && nmi_strobe == '0 && !injected));
   assert_lowpri_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_dlv_mode == DLV_LOWPRI) |=> $onehot0(vec_strobe));
   assert_pin0_steer_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && pin_zero && req_dlv_mode == DLV_FIXED) |=> ((vec_strobe >> 1) == '0));
endmodule

// File: tb/ird_dispatch_test.sv
module ird_dispatch_test;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [4:0]   req_pin = '0;
   logic [7:0]   req_dest = '0;
   logic         req_dest_mode = 1'b0;
   logic [2:0]   req_dlv_mode = '0;
   logic [7:0]   req_vector = '0;
   logic [N-1:0] cpu_present = '0;
   logic [N*8-1:0] cpu_phys_id = '0;
   logic [N*8-1:0] cpu_logic_id = '0;
   logic [2:0]   lp_choice = '0;
   logic [N-1:0] vec_strobe;
   logic [7:0]   vec_out;
   logic [N-1:0] nmi_strobe;
   logic         injected;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   int e_vec, e_nmi, e_vout, e_inj;

   always #5 clk = ~clk;

   ird_dispatch uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pin(req_pin),
      .req_dest(req_dest), .req_dest_mode(req_dest_mode), .req_dlv_mode(req_dlv_mode),
      .req_vector(req_vector), .cpu_present(cpu_present), .cpu_phys_id(cpu_phys_id),
      .cpu_logic_id(cpu_logic_id), .lp_choice(lp_choice), .vec_strobe(vec_strobe),
      .vec_out(vec_out), .nmi_strobe(nmi_strobe), .injected(injected)
   );

   task automatic set_ids(input int pid[8], input int lid[8]);
      for (int i = 0; i < N; i++) begin
         cpu_phys_id[i*8 +: 8]  = pid[i][7:0];
         cpu_logic_id[i*8 +: 8] = lid[i][7:0];
      end
   endtask

   // behavioural reference of the requirements
   task automatic model();
      int mask = 0;
      int pres = int'(cpu_present);
      int d = int'(req_dest);
      e_vec = 0; e_nmi = 0; e_vout = 0; e_inj = 0;
      if (!req_valid) return;
      if (req_dest_mode == 1'b0) begin
         if (d == 255) mask = pres;
         else begin
            for (int i = 0; i < N; i++) begin
               if (pres[i] && int'(cpu_phys_id[i*8 +: 8]) == d) begin
                  mask = 1 << i;
                  break;
               end
            end
         end
      end else if (d != 0) begin
         for (int i = 0; i < N; i++)
            if (pres[i] && (int'(cpu_logic_id[i*8 +: 8]) & d) != 0) mask |= (1 << i);
      end
      if (mask != 0) begin
         if (req_dlv_mode == 3'b000) begin
            e_vec = (req_pin == 0) ? (pres & 1) : mask;
         end else if (req_dlv_mode == 3'b001) begin
            if (req_pin == 0) e_vec = pres & 1;
            else if (mask[int'(lp_choice)]) e_vec = 1 << int'(lp_choice);
            else begin
               for (int i = 0; i < N; i++)
                  if (mask[i]) begin e_vec = 1 << i; break; end
            end
         end else if (req_dlv_mode == 3'b100) begin
            e_nmi = mask;
         end
      end
      e_inj  = (e_vec != 0) ? 1 : 0;
      e_vout = (e_inj != 0) ? int'(req_vector) : 0;
   endtask

   task automatic compare(input string tag);
      n_vec++;
      if (int'(vec_strobe) != e_vec) begin
         n_bad++;
         $display("FAIL %s vec_strobe actual=%h expected=%h", tag, vec_strobe, e_vec);
      end
      if (int'(nmi_strobe) != e_nmi) begin
         n_bad++;
         $display("FAIL %s nmi_strobe actual=%h expected=%h", tag, nmi_strobe, e_nmi);
      end
      if (int'(vec_out) != e_vout) begin
         n_bad++;
         $display("FAIL %s vec_out actual=%h expected=%h", tag, vec_out, e_vout);
      end
      if (int'(injected) != e_inj) begin
         n_bad++;
         $display("FAIL %s injected actual=%0d expected=%0d", tag, injected, e_inj);
      end
   endtask

   // called at a falling edge with inputs set; checks result one clock later
   task automatic step(input string tag);
      model();
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic req(input int pin, input int dest, input int dm, input int mode,
                      input int vec, input int choice, input string tag);
      req_valid = 1'b1; req_pin = pin[4:0]; req_dest = dest[7:0];
      req_dest_mode = dm[0]; req_dlv_mode = mode[2:0]; req_vector = vec[7:0];
      lp_choice = choice[2:0];
      step(tag);
   endtask

   task automatic idle(input string tag);
      req_valid = 1'b0;
      step(tag);
   endtask

   initial begin
      int pid[8] = '{8'h10, 8'h11, 8'h22, 8'h13, 8'h14, 8'h22, 8'h16, 8'h17};
      int lid[8] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h03, 8'h40, 8'h80};
      set_ids(pid, lid);
      cpu_present = 8'b1110_1111;
      @(negedge clk);
      e_vec = 0; e_nmi = 0; e_vout = 0; e_inj = 0;
      compare("R11 reset");
      @(negedge clk);
      rst_n = 1'b1;
      idle("R11 idle after reset");
      req(3, 8'hFF, 0, 3'b000, 8'h41, 0, "R1 broadcast fixed");
      req(3, 8'h22, 0, 3'b000, 8'h42, 0, "R2 first match");
      cpu_present = 8'b1110_1011;
      req(3, 8'h22, 0, 3'b000, 8'h43, 0, "R2 later duplicate");
      cpu_present = 8'b1110_1111;
      req(3, 8'h99, 0, 3'b000, 8'h44, 0, "R5 no physical match");
      req(3, 8'h00, 1, 3'b000, 8'h45, 0, "R3 logical zero");
      req(3, 8'h05, 1, 3'b000, 8'h46, 0, "R4 logical overlap");
      req(3, 8'h10, 1, 3'b000, 8'h47, 0, "R4 R5 absent logical");
      req(3, 8'h07, 1, 3'b000, 8'h48, 0, "R6 fixed multi");
      req(3, 8'h07, 1, 3'b001, 8'h49, 2, "R7 choice in set");
      req(3, 8'h06, 1, 3'b001, 8'h4A, 6, "R7 choice fallback");
      req(0, 8'h0C, 1, 3'b000, 8'h4B, 0, "R8 pin0 fixed");
      req(0, 8'h0C, 1, 3'b001, 8'h4C, 3, "R8 pin0 lowpri");
      cpu_present = 8'b1110_1110;
      req(0, 8'hFF, 0, 3'b000, 8'h4D, 0, "R8 pin0 cpu0 absent");
      req(0, 8'h00, 1, 3'b000, 8'h4E, 0, "R8 R5 pin0 empty");
      cpu_present = 8'b1110_1111;
      req(3, 8'hFF, 0, 3'b100, 8'h4F, 0, "R9 nmi broadcast");
      req(0, 8'h05, 1, 3'b100, 8'h50, 0, "R9 nmi pin0");
      req(3, 8'hFF, 0, 3'b010, 8'h51, 0, "R10 mode 010");
      req(3, 8'hFF, 0, 3'b111, 8'h52, 0, "R10 mode 111");
      idle("R11 pulse ends");
      req(4, 8'h11, 0, 3'b000, 8'h53, 0, "R11 back to back a");
      req(5, 8'h13, 0, 3'b000, 8'h54, 0, "R11 back to back b");
      idle("R11 idle");
      for (int k = 0; k < 400; k++) begin
         int modes[6] = '{0, 1, 4, 0, 2, 1};
         int m = modes[$urandom_range(0, 5)];
         int dsel = $urandom_range(0, 3);
         int dest;
         for (int i = 0; i < N; i++) begin
            pid[i] = 8'h20 + $urandom_range(0, 3);
            lid[i] = $urandom_range(0, 255);
         end
         set_ids(pid, lid);
         cpu_present = N'($urandom);
         dest = (dsel == 0) ? 255 : (dsel == 1) ? 8'h20 + $urandom_range(0, 3)
              : $urandom_range(0, 255);
         if ($urandom_range(0, 7) == 0) idle("R11 random idle");
         else req($urandom_range(0, 3), dest, $urandom_range(0, 1), m,
                  $urandom_range(0, 255), $urandom_range(0, 7),
                  (m == 1) ? "R7 random" : (m == 4) ? "R9 random"
                  : (m == 0) ? "R6 random" : "R10 random");
      end
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R11 watchdog actual=running expected=done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule